// File: doc/BRIEF.md
# I2C Role and Direction Controller

This block holds the two state bits that define how an I2C serial interface takes part in a transfer. The role bit selects master or slave, and the direction bit selects transmitter or receiver. Software loads both bits through a small write port. Bus events then change them: an address phase that completes, a stop condition on the bus, or a lost arbitration. The block also issues a one-cycle start request when software asks for a start while the bus is idle. Bit shifting and SCL timing belong to neighbouring logic.

After an address phase completes, hardware sets the direction bit. The rule for a master is the opposite of the rule for a slave. A slave whose address matched takes the R/W bit it received. A master whose address was acknowledged takes the inverse of the R/W bit it sent. In free-format mode and in no-acknowledge mode there is no address recognition, so hardware leaves the direction bit alone.

Where events coincide in one cycle, a hardware clear wins over a software write, and a software write wins over the address-phase update.

Top module: `i2c_role_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `master_o`, `trx_o` and `start_req_o` are 0.
- R2: A write whose 4-bit value is not 4'b1111 loads `master_o` from bit 3 and `trx_o` from bit 2 on the next clock edge. Bits 1 and 0 (busy, pending) have no further effect.
- R3: A write of 4'b1111 (master, transmitter, busy and pending all 1) with `bus_busy_i` low sets `master_o` and `trx_o` to 1. On the same edge `start_req_o` goes high, and it stays high for exactly one cycle.
- R4: A write of 4'b1111 while `bus_busy_i` is high is ignored. `master_o` and `trx_o` keep their values and `start_req_o` stays low.
- R5: A pulse on `stop_det_i` or `arb_lost_i` clears `master_o` and `trx_o` on the next edge. It also overrides, and suppresses any start request from, a write in the same cycle.
- R6: Slave address update. When the address phase completes (`addr_done_i`) while `master_o` is 0 and `addr_match_i` is 1, `trx_o` takes `rw_bit_i`. Without a match, `trx_o` is unchanged.
- R7: Master acknowledge update. When the address phase completes while `master_o` is 1 and `ack_rcvd_i` is 1, `trx_o` takes the inverse of `rw_bit_i`.
- R8: Master missing acknowledge. When the address phase completes while `master_o` is 1 and `ack_rcvd_i` is 0, `trx_o` keeps its value.
- R9: When `no_ack_mode_i` is 1, completion of an address phase never changes `trx_o`.
- R10: When `free_fmt_i` is 1, completion of an address phase never changes `trx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 4 | Write value: bit 3 master, bit 2 transmitter, bit 1 busy, bit 0 pending |
| bus_busy_i | input | 1 | Bus is currently busy |
| free_fmt_i | input | 1 | Free data format mode |
| no_ack_mode_i | input | 1 | No-acknowledge mode |
| addr_done_i | input | 1 | Pulse marking the end of the address phase, including the acknowledge slot |
| rw_bit_i | input | 1 | R/W bit received (slave role) or sent (master role) |
| addr_match_i | input | 1 | Received address matches the own address |
| ack_rcvd_i | input | 1 | Acknowledge seen after the address byte |
| stop_det_i | input | 1 | Stop condition detected, one-cycle pulse |
| arb_lost_i | input | 1 | Arbitration lost, one-cycle pulse |
| master_o | output | 1 | Role bit: 1 master, 0 slave |
| trx_o | output | 1 | Direction bit: 1 transmitter, 0 receiver |
| start_req_o | output | 1 | One-cycle start request |

## Verification
The two state bits are outputs, so any wrong internal state appears on `master_o` or `trx_o` one cycle after the event that caused it. A wrong role bit may also hide until the next address phase, when it selects the wrong update rule and `trx_o` takes a flipped R/W value. For that reason the checks follow each role write with an address phase. A start request that is lost, arrives late, or stretches past one cycle shows on `start_req_o` at the first edge after the write.

// File: rtl/i2c_role_pkg.sv
package i2c_role_pkg;
  localparam int unsigned WR_W    = 4;
  localparam int unsigned BIT_MST = 3;
  localparam int unsigned BIT_TRX = 2;
  localparam int unsigned BIT_BB  = 1;
  localparam int unsigned BIT_PIN = 0;
  localparam logic [WR_W-1:0] START_CODE = '1;

  typedef struct packed {
    logic master;
    logic trx;
  } role_t;
endpackage

// File: rtl/role_start_gen.sv
module role_start_gen
  import i2c_role_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            bus_busy_i,
  input  logic            clr_i,
  output logic            start_hit_o,
  output logic            start_drop_o,
  output logic            start_req_o
);
  logic is_start;

  assign is_start     = wr_en_i && (wr_data_i == START_CODE);
  assign start_hit_o  = is_start && !bus_busy_i && !clr_i;
  assign start_drop_o = is_start && bus_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_req_o <= 1'b0;
    else         start_req_o <= start_hit_o;
  end

  // R3: the request lasts one cycle unless a second start is written at once
  p_start_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o && !start_hit_o |=> !start_req_o);
  // R4
  p_busy_nostart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_drop_o |=> !start_req_o);
endmodule

// File: rtl/role_dir_next.sv
module role_dir_next (
  input  logic master_i,
  input  logic addr_done_i,
  input  logic free_fmt_i,
  input  logic no_ack_mode_i,
  input  logic rw_bit_i,
  input  logic addr_match_i,
  input  logic ack_rcvd_i,
  output logic upd_o,
  output logic trx_o
);
  logic recog;

  // free format and no-ack mode skip address recognition entirely
  assign recog = addr_done_i && !free_fmt_i && !no_ack_mode_i;

  always_comb begin
    upd_o = 1'b0;
    trx_o = 1'b0;
    if (recog) begin
      if (master_i) begin
        upd_o = ack_rcvd_i;
        trx_o = !rw_bit_i;
      end else begin
        upd_o = addr_match_i;
        trx_o = rw_bit_i;
      end
    end
  end
endmodule

// File: rtl/i2c_role_ctrl.sv
module i2c_role_ctrl
  import i2c_role_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            bus_busy_i,
  input  logic            free_fmt_i,
  input  logic            no_ack_mode_i,
  input  logic            addr_done_i,
  input  logic            rw_bit_i,
  input  logic            addr_match_i,
  input  logic            ack_rcvd_i,
  input  logic            stop_det_i,
  input  logic            arb_lost_i,
  output logic            master_o,
  output logic            trx_o,
  output logic            start_req_o
);
  role_t st_q, st_d;
  logic  clr, start_hit, start_drop, hw_upd, hw_trx;

  assign clr = stop_det_i || arb_lost_i;

  role_start_gen u_start (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .bus_busy_i  (bus_busy_i),
    .clr_i       (clr),
    .start_hit_o (start_hit),
    .start_drop_o(start_drop),
    .start_req_o (start_req_o)
  );

  role_dir_next u_dir (
    .master_i     (st_q.master),
    .addr_done_i  (addr_done_i),
    .free_fmt_i   (free_fmt_i),
    .no_ack_mode_i(no_ack_mode_i),
    .rw_bit_i     (rw_bit_i),
    .addr_match_i (addr_match_i),
    .ack_rcvd_i   (ack_rcvd_i),
    .upd_o        (hw_upd),
    .trx_o        (hw_trx)
  );

  // priority: hardware clear > software write > address-phase update
  always_comb begin
    st_d = st_q;
    if (clr) begin
      st_d = '0;
    end else if (wr_en_i) begin
      if (start_hit) begin
        st_d.master = 1'b1;
        st_d.trx    = 1'b1;
      end else if (!start_drop) begin
        st_d.master = wr_data_i[BIT_MST];
        st_d.trx    = wr_data_i[BIT_TRX];
      end
    end else if (hw_upd) begin
      st_d.trx = hw_trx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign master_o = st_q.master;
  assign trx_o    = st_q.trx;

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !master_o && !trx_o && !start_req_o);
  p_start_role_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |-> master_o && trx_o);
  p_busy_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i == START_CODE && bus_busy_i && !clr
    |=> $stable(master_o) && $stable(trx_o));
  p_slave_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr && !wr_en_i && addr_done_i && !free_fmt_i && !no_ack_mode_i && !master_o && addr_match_i
    |=> trx_o == $past(rw_bit_i));
  p_master_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr && !wr_en_i && addr_done_i && !free_fmt_i && !no_ack_mode_i && master_o && ack_rcvd_i
    |=> trx_o != $past(rw_bit_i));
  p_master_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr && !wr_en_i && addr_done_i && master_o && !ack_rcvd_i |=> $stable(trx_o));
  p_noack_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr && !wr_en_i && no_ack_mode_i |=> $stable(trx_o));
  p_free_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr && !wr_en_i && free_fmt_i |=> $stable(trx_o));
endmodule

// File: tb/sim_i2c_role_ctrl.sv
module sim_i2c_role_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, busy = 0, free_f = 0, noack = 0, done = 0, rw = 0, match = 0, ack = 0, stop = 0, arb = 0;
  logic [3:0] wdata = 4'h0;
  logic master, trx, sreq;
  int checks = 0, errors = 0, cycles = 0;
  logic m_exp = 0, t_exp = 0;
  bit finished = 0;

  typedef struct {
    logic m;
    logic t;
    logic s;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  i2c_role_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wdata), .bus_busy_i(busy),
    .free_fmt_i(free_f), .no_ack_mode_i(noack), .addr_done_i(done), .rw_bit_i(rw),
    .addr_match_i(match), .ack_rcvd_i(ack), .stop_det_i(stop), .arb_lost_i(arb),
    .master_o(master), .trx_o(trx), .start_req_o(sreq)
  );

  task automatic cmp(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {master,trx,start} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] d, input logic b, input logic ff,
                      input logic na, input logic dn, input logic r, input logic mt,
                      input logic ak, input logic sp, input logic al, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = w; wdata = d; busy = b; free_f = ff; noack = na; done = dn;
    rw = r; match = mt; ack = ak; stop = sp; arb = al;
    e.s = 1'b0;
    if (sp || al) begin
      m_exp = 0; t_exp = 0;
    end else if (w) begin
      if (d == 4'hF) begin
        if (!b) begin m_exp = 1; t_exp = 1; e.s = 1'b1; end
      end else begin
        m_exp = d[3]; t_exp = d[2];
      end
    end else if (dn && !ff && !na) begin
      if (m_exp) begin if (ak) t_exp = !r; end
      else if (mt) t_exp = r;
    end
    e.m = m_exp; e.t = t_exp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(0, 4'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: compare one expected item per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, {master, trx, sreq}, {e.m, e.t, e.s});
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !finished) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    #1;
    cmp("R1", {master, trx, sreq}, 3'b000);
    repeat (3) @(negedge clk);
    cmp("R1", {master, trx, sreq}, 3'b000);
    rst_n = 1'b1;
    idle("R1");
    // R2: writes that are not the start code load the role bits
    step(1, 4'b1000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 4'b0111, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 4'b1110, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R6: slave update on address match, hold without match
    step(0, 4'h0, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R6");
    step(0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R6");
    step(0, 4'h0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R6");
    // R3: start with idle bus
    step(1, 4'hF, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    idle("R3");
    // R7: master acknowledged, read direction
    step(0, 4'h0, 0, 0, 0, 1, 1, 0, 1, 0, 0, "R7");
    step(0, 4'h0, 0, 0, 0, 1, 0, 0, 1, 0, 0, "R7");
    // R8: master without acknowledge holds
    step(0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8");
    step(0, 4'h0, 0, 0, 0, 1, 1, 0, 1, 0, 0, "R7");
    step(0, 4'h0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8");
    // R5: stop clears
    step(0, 4'h0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R5");
    // R4: start while busy is ignored (from cleared state and from a set state)
    step(1, 4'hF, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 4'b1000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 4'hF, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 4'h0, 0, 0, 0, 1, 0, 0, 1, 0, 0, "R4");
    // R5: arbitration loss wins over same-cycle start write
    step(1, 4'hF, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R5");
    idle("R5");
    step(1, 4'b1100, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 4'b1100, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R5");
    // R9: no-ack mode suppresses slave and master updates
    step(0, 4'h0, 0, 0, 1, 1, 1, 1, 0, 0, 0, "R9");
    step(1, 4'b1000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 4'h0, 0, 0, 1, 1, 0, 0, 1, 0, 0, "R9");
    // R10: free format suppresses updates
    step(0, 4'h0, 0, 1, 0, 1, 0, 0, 1, 0, 0, "R10");
    step(1, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 4'h0, 0, 1, 0, 1, 1, 1, 0, 0, 0, "R10");
    step(0, 4'h0, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R6");
    idle("R6");
    idle("R6");
    wait (q.size() == 0);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule